// File: doc/BRIEF.md
# ECC Read-Modify-Write Byte Merge Unit

This block carries out a write narrower than a full 64-bit word to a memory protected by an error-correcting code. The checkbits of a location cover all eight bytes, so a write of only some bytes cannot be encoded on its own. The unit first fetches the word that the location currently holds. It then forms a composite word: each byte lane takes either the new system byte or the old memory byte. It encodes fresh checkbits over that composite and presents data and checkbits together as a single memory write.

A request carries 64 bits of system data and an 8-bit lane mask. When every lane is enabled, the write already covers the full word, so the read is skipped and the data is encoded directly. Otherwise the unit asks for the old word and waits as long as the memory needs to return it. The merged word and its checkbits are registered. The write is then held until the memory accepts it, and completion is signalled with a one-cycle pulse.

Top module: `ecc_byte_merge`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `req_ready` is 1 and `mem_rd_req`, `mem_wr_en` and `done` are 0. This holds even when reset arrives in the middle of an operation.
- R2: Bit k of the captured lane mask picks byte lane k (bits 8k+7..8k) of `mem_wr_data`. A 1 takes that byte from `req_wdata`, and a 0 takes it from `mem_rd_data`.
- R3: The checkbits follow a fixed code. Data bit i is placed at the i-th position, counting upward from 3, that is not a power of two (positions 3..71). Bit j of `mem_wr_chk`, for j<7, is the XOR of the data bits whose position has bit j set. Bit 7 is the XOR of all 64 data bits and of check bits 6..0. The whole 8-bit result is then XORed with 0x0C.
- R4: `mem_wr_chk` is always the code of the complete merged word that appears on `mem_wr_data` in the same cycle, never the code of the system bytes alone.
- R5: If a request is accepted with a mask other than 0xFF, `mem_rd_req` rises in the next cycle. It stays high until a cycle in which `mem_rd_valid` is 1, and `mem_wr_en` is 0 throughout.
- R6: If a request is accepted with mask 0xFF, `mem_rd_req` never rises. `mem_wr_en` rises in the second cycle after acceptance, carrying `req_wdata` unchanged.
- R7: `mem_wr_en` rises in the cycle after the one in which `mem_rd_valid` is seen during a read request. It stays high, with `mem_wr_data` and `mem_wr_chk` stable, until a cycle in which `mem_wr_ready` is 1.
- R8: In the cycle after the write is accepted, `done` is 1 for exactly one cycle and `req_ready` is 1 again.
- R9: `req_valid` has no effect while `req_ready` is 0. Data and mask offered then do not alter the word that is written.
- R10: An all-zero merged word is written with checkbits 0x0C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A write request is offered |
| req_ready | output | 1 | Unit is idle and takes a request this cycle |
| req_be | input | 8 | Lane mask, 1 = system byte |
| req_wdata | input | 64 | System-side write data |
| mem_rd_req | output | 1 | Request for the old contents of the location |
| mem_rd_valid | input | 1 | Old word present on mem_rd_data |
| mem_rd_data | input | 64 | Old word read from memory |
| mem_wr_en | output | 1 | Composite write presented |
| mem_wr_ready | input | 1 | Memory accepts the write this cycle |
| mem_wr_data | output | 64 | Merged data word |
| mem_wr_chk | output | 8 | Checkbits of the merged word |
| done | output | 1 | One-cycle completion pulse |

## Verification
Inputs are driven on the falling edge and outputs are sampled on the next falling edge, so every result is read a whole number of rising edges after its cause. The read request is due one edge after acceptance. The merged write is due one edge after the read data is taken on a partial mask, or two edges after acceptance on a full mask. `done` is due one edge after `mem_wr_ready` and is gone one edge later. The bench checks the write at exactly those samples and, when it stalls the read or the write, re-checks the held outputs on every stalled cycle.

// File: rtl/ecc_merge_pkg.sv
package ecc_merge_pkg;

    parameter int unsigned DATA_W   = 64;
    parameter int unsigned LANE_W   = 8;
    parameter int unsigned LANES    = DATA_W / LANE_W;
    parameter int unsigned CHK_W    = 8;
    parameter int unsigned HAM_W    = CHK_W - 1;
    parameter logic [CHK_W-1:0] CHK_FLIP = 8'h0C;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ_REQ,
        ST_MERGE,
        ST_WRITE
    } merge_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CHK_W-1:0]  chk;
    } coded_word_t;

    // Hamming positions skip powers of two; overall parity in the top bit.
    function automatic logic [CHK_W-1:0] encode_word(input logic [DATA_W-1:0] d);
        logic [CHK_W-1:0] c;
        logic [HAM_W:0]   pos;
        logic [HAM_W:0]   one;
        c   = '0;
        one = {{HAM_W{1'b0}}, 1'b1};
        pos = one + one;
        for (int i = 0; i < int'(DATA_W); i++) begin
            pos = pos + one;
            if ((pos & (pos - one)) == '0) pos = pos + one;
            for (int j = 0; j < int'(HAM_W); j++) begin
                if (pos[j]) c[j] = c[j] ^ d[i];
            end
        end
        c[CHK_W-1] = (^d) ^ (^c[HAM_W-1:0]);
        return c ^ CHK_FLIP;
    endfunction

endpackage

// File: rtl/byte_lane_mux.sv
module byte_lane_mux
    import ecc_merge_pkg::*;
(
    input  logic [LANES-1:0]  lane_sel,
    input  logic [DATA_W-1:0] sys_word,
    input  logic [DATA_W-1:0] mem_word,
    output logic [DATA_W-1:0] merged
);
    for (genvar k = 0; k < int'(LANES); k++) begin : g_lane
        assign merged[k*LANE_W +: LANE_W] = lane_sel[k] ? sys_word[k*LANE_W +: LANE_W]
                                                        : mem_word[k*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/secded_encoder.sv
module secded_encoder
    import ecc_merge_pkg::*;
(
    input  logic [DATA_W-1:0] data_in,
    output coded_word_t       coded
);
    always_comb begin
        coded.data = data_in;
        coded.chk  = encode_word(data_in);
    end
endmodule

// File: rtl/merge_seq_fsm.sv
module merge_seq_fsm
    import ecc_merge_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic full_mask,
    input  logic rd_valid,
    input  logic wr_ready,
    output logic req_ready,
    output logic accept,
    output logic rd_req,
    output logic wr_en,
    output logic load_res,
    output logic done
);
    merge_state_e state_q, state_d;
    logic         done_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = full_mask ? ST_MERGE : ST_READ_REQ;
            ST_READ_REQ: if (rd_valid)  state_d = ST_WRITE;
            ST_MERGE:                   state_d = ST_WRITE;
            ST_WRITE:    if (wr_ready)  state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_WRITE) && wr_ready;
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign rd_req    = (state_q == ST_READ_REQ);
    assign wr_en     = (state_q == ST_WRITE);
    assign load_res  = (state_q == ST_MERGE) || (rd_req && rd_valid);
    assign done      = done_q;
endmodule

// File: rtl/ecc_byte_merge.sv
module ecc_byte_merge
    import ecc_merge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              mem_rd_req,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    input  logic              mem_wr_ready,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic [CHK_W-1:0]  mem_wr_chk,
    output logic              done
);
    logic              accept;
    logic              load_res;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] merged;
    coded_word_t       coded;
    coded_word_t       res_q;

    merge_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .full_mask (&req_be),
        .rd_valid  (mem_rd_valid),
        .wr_ready  (mem_wr_ready),
        .req_ready (req_ready),
        .accept    (accept),
        .rd_req    (mem_rd_req),
        .wr_en     (mem_wr_en),
        .load_res  (load_res),
        .done      (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            be_q    <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            be_q    <= req_be;
            wdata_q <= req_wdata;
        end
    end

    byte_lane_mux u_mux (
        .lane_sel (be_q),
        .sys_word (wdata_q),
        .mem_word (mem_rd_data),
        .merged   (merged)
    );

    secded_encoder u_enc (
        .data_in (merged),
        .coded   (coded)
    );

    always_ff @(posedge clk) begin
        if (rst)           res_q <= '0;
        else if (load_res) res_q <= coded;
    end

    assign mem_wr_data = res_q.data;
    assign mem_wr_chk  = res_q.chk;
endmodule

// File: rtl/ecc_byte_merge_chk.sv
module ecc_byte_merge_chk
    import ecc_merge_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LANES-1:0]  req_be,
    input logic              mem_rd_req,
    input logic              mem_rd_valid,
    input logic              mem_wr_en,
    input logic              mem_wr_ready,
    input logic [DATA_W-1:0] mem_wr_data,
    input logic [CHK_W-1:0]  mem_wr_chk,
    input logic              done
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (req_ready && !mem_rd_req && !mem_wr_en && !done));

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && !mem_wr_en));

    // R5
    partial_reads_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !(&req_be)) |=> mem_rd_req);

    // R6
    full_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (&req_be)) |=> (!mem_rd_req && !mem_wr_en) ##1 mem_wr_en);

    // R7
    wr_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && mem_rd_valid) |=> mem_wr_en);

    // R7
    wr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && !mem_wr_ready) |=>
            (mem_wr_en && $stable(mem_wr_data) && $stable(mem_wr_chk)));

    // R8
    done_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && mem_wr_ready) |=> (done && req_ready));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    zero_code_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && (mem_wr_data == '0)) |-> (mem_wr_chk == 8'h0C));
endmodule

bind ecc_byte_merge ecc_byte_merge_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_be       (req_be),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_valid (mem_rd_valid),
    .mem_wr_en    (mem_wr_en),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_chk   (mem_wr_chk),
    .done         (done)
);

// File: tb/ecc_byte_merge_tb_top.sv
module ecc_byte_merge_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [7:0]  req_be;
    logic [63:0] req_wdata;
    logic        mem_rd_req;
    logic        mem_rd_valid;
    logic [63:0] mem_rd_data;
    logic        mem_wr_en;
    logic        mem_wr_ready;
    logic [63:0] mem_wr_data;
    logic [7:0]  mem_wr_chk;
    logic        done;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ecc_byte_merge dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_be(req_be), .req_wdata(req_wdata),
        .mem_rd_req(mem_rd_req), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_ready(mem_wr_ready),
        .mem_wr_data(mem_wr_data), .mem_wr_chk(mem_wr_chk),
        .done(done)
    );

    localparam int NV = 7;
    localparam logic [7:0]  V_BE [NV] = '{8'h00, 8'hFF, 8'h0F, 8'h81, 8'h5A, 8'h01, 8'hFF};
    localparam logic [63:0] V_WD [NV] = '{64'h1111_2222_3333_4444, 64'h0123_4567_89AB_CDEF,
                                           64'hAAAA_AAAA_AAAA_AAAA, 64'hDEAD_BEEF_CAFE_F00D,
                                           64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_00C3,
                                           64'h0};
    localparam logic [63:0] V_RD [NV] = '{64'h0, 64'h7777_7777_7777_7777,
                                           64'h5555_5555_5555_5555, 64'h0F1E_2D3C_4B5A_6978,
                                           64'h0, 64'h8000_0000_0000_0001,
                                           64'h9999_9999_9999_9999};
    localparam int          V_RW [NV] = '{0, 0, 2, 1, 0, 3, 0};
    localparam int          V_WW [NV] = '{0, 2, 0, 3, 1, 0, 0};
    localparam bit          V_PK [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_merge(input logic [7:0] be, input logic [63:0] s, input logic [63:0] m);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[k*8 +: 8] = be[k] ? s[k*8 +: 8] : m[k*8 +: 8];
        return r;
    endfunction

    // Builds the 71-bit codeword and reads the check sums off it.
    function automatic logic [7:0] ref_chk(input logic [63:0] d);
        logic [71:0] cw;
        logic [7:0]  c;
        int          idx;
        cw  = '0;
        idx = 0;
        for (int p = 1; p < 72; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = d[idx];
                idx++;
            end
        end
        c = '0;
        for (int j = 0; j < 7; j++)
            for (int p = 1; p < 72; p++)
                if (((p >> j) & 1) == 1) c[j] = c[j] ^ cw[p];
        c[7] = (^d) ^ (^c[6:0]);
        return c ^ 8'h0C;
    endfunction

    task automatic txn(input logic [7:0] be, input logic [63:0] wd, input logic [63:0] rd,
                       input int rwait, input int wwait, input bit poke);
        logic [63:0] exp_d;
        logic [7:0]  exp_c;
        exp_d = ref_merge(be, wd, rd);
        exp_c = ref_chk(exp_d);
        @(negedge clk);
        check(req_ready == 1'b1, "R8", {63'd0, req_ready}, 64'd1);
        req_valid = 1'b1; req_be = be; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_be = 8'h00; req_wdata = 64'hBAD0_BAD0_BAD0_BAD0;
        if (be != 8'hFF) begin
            check(mem_rd_req && !mem_wr_en, "R5", {62'd0, mem_rd_req, mem_wr_en}, 64'h2);
            for (int k = 0; k < rwait; k++) begin
                if (poke) begin  // R9: offers while busy
                    req_valid = 1'b1; req_be = ~be; req_wdata = ~wd;
                end
                @(negedge clk);
                req_valid = 1'b0;
                check(mem_rd_req && !mem_wr_en, "R5", {62'd0, mem_rd_req, mem_wr_en}, 64'h2);
            end
            mem_rd_valid = 1'b1; mem_rd_data = rd;
            @(negedge clk);
            mem_rd_valid = 1'b0; mem_rd_data = ~rd;
            check(mem_wr_en == 1'b1, "R7", {63'd0, mem_wr_en}, 64'd1);
        end else begin
            check(!mem_rd_req && !mem_wr_en, "R6", {62'd0, mem_rd_req, mem_wr_en}, 64'h0);
            @(negedge clk);
            check(mem_wr_en && !mem_rd_req, "R6", {62'd0, mem_rd_req, mem_wr_en}, 64'h1);
            check(mem_wr_data == wd, "R6", mem_wr_data, wd);
        end
        check(mem_wr_data == exp_d, poke ? "R9" : "R2", mem_wr_data, exp_d);
        check(mem_wr_chk == exp_c, "R3", {56'd0, mem_wr_chk}, {56'd0, exp_c});
        check(mem_wr_chk == ref_chk(mem_wr_data), "R4", {56'd0, mem_wr_chk}, {56'd0, ref_chk(mem_wr_data)});
        if (exp_d == 64'd0)
            check(mem_wr_chk == 8'h0C, "R10", {56'd0, mem_wr_chk}, 64'h0C);
        for (int k = 0; k < wwait; k++) begin
            @(negedge clk);
            check(mem_wr_en && mem_wr_data == exp_d && mem_wr_chk == exp_c, "R7", mem_wr_data, exp_d);
        end
        mem_wr_ready = 1'b1;
        @(negedge clk);
        mem_wr_ready = 1'b0;
        check(done && req_ready && !mem_wr_en, "R8", {61'd0, done, req_ready, mem_wr_en}, 64'h6);
        @(negedge clk);
        check(!done, "R8", {63'd0, done}, 64'd0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_be = '0; req_wdata = '0;
        mem_rd_valid = 1'b0; mem_rd_data = '0; mem_wr_ready = 1'b0;
        repeat (3) @(negedge clk);
        check(req_ready && !mem_rd_req && !mem_wr_en && !done, "R1",
              {60'd0, req_ready, mem_rd_req, mem_wr_en, done}, 64'h8);
        rst = 1'b0;

        for (int v = 0; v < NV; v++)
            txn(V_BE[v], V_WD[v], V_RD[v], V_RW[v], V_WW[v], V_PK[v]);

        // R1: reset in the middle of a held write
        @(negedge clk);
        req_valid = 1'b1; req_be = 8'h3C; req_wdata = 64'h1234;
        @(negedge clk);
        req_valid = 1'b0;
        mem_rd_valid = 1'b1; mem_rd_data = 64'h5678;
        @(negedge clk);
        mem_rd_valid = 1'b0;
        check(mem_wr_en == 1'b1, "R7", {63'd0, mem_wr_en}, 64'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(req_ready && !mem_rd_req && !mem_wr_en && !done, "R1",
              {60'd0, req_ready, mem_rd_req, mem_wr_en, done}, 64'h8);

        // R9: offer while idle-after-reset then busy, with a zero merge (R10)
        txn(8'hF0, 64'h0, 64'h0, 2, 1, 1'b1);

        summary();
    end

endmodule